// File: doc/BRIEF.md
# Static Scoreboard Hazard Interlock

This unit sits beside the decode stage of an in-order eight-stage pipeline. The stages are numbered 0 to 7 in this order: two fetch stages, decode (2), two execute stages (3, 4), two memory stages (5, 6) and writeback (7). For every instruction that has left decode and has not yet reached writeback, the unit keeps a small record. The record holds the destination register and the stage at whose start that result can first be forwarded.

When a new instruction arrives in decode, the unit looks up each of its source operands against those records. Each operand carries the stage at which it must be present. The youngest matching producer decides the operand's wait. The unit then holds decode for the smallest number of cycles after which forwarding can deliver every operand, and one bubble enters the pipeline per held cycle. It also reports, per source, the stage in which the hazarding producer was found.

The decode instruction is offered on a valid/ready pair. While `id_ready` is low, the offering side must keep `id_valid` high and every `id_*` field unchanged. The instruction is taken, and its destination recorded, on the first clock edge where both are high. Hazard reports are given only in the first cycle an instruction is offered.

Top module: `ssi_interlock`

## Requirements
- R1: After reset no producer is recorded, so `id_ready` is high and `haz_hit` is zero for any source.
- R2: A recorded producer that is d stages ahead of decode (d=1 in stage 3 up to d=4 in stage 6) and is forwardable from stage R causes a source needed at stage N to wait max(0, R−N−d) cycles. Decode stalls for the largest wait over all of its sources.
- R3: Register tag 0 is never recorded as a destination, and a source with tag 0 never reports a hazard.
- R4: When several recorded producers write the same tag, only the youngest one (smallest d) sets the hit, the stage and the wait.
- R5: `id_ready` stays low for exactly the stall count and then rises. An instruction is taken only on an edge with `id_valid` and `id_ready` both high, and its destination is recorded at d=1 in the next cycle.
- R6: In the first cycle an instruction is offered, `haz_hit[s]` is 1 if source s matched a producer, and `haz_stage[3s+2:3s]` gives that producer's current stage code (3 to 6). Both are zero in the later, held cycles of the same instruction.
- R7: Each held cycle places a bubble at d=1, and a bubble records no destination.
- R8: Tag 32 names the hi/lo pair and is tracked exactly like a general register.
- R9: A producer in writeback (d=5) never causes a hazard.
- R10: With two sources that hit different producers, the stall is the larger of the two waits, and each source reports its own stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | An instruction is offered in decode |
| id_ready | output | 1 | Decode may advance this cycle |
| id_dst_en | input | 1 | The offered instruction writes a register |
| id_dst_tag | input | 6 | Destination tag (0..31 general, 32 hi/lo) |
| id_dst_rdy | input | 3 | Stage code from which the result is forwardable |
| id_src_en | input | NSRC | Per-source enable |
| id_src_tag | input | 6*NSRC | Per-source register tag |
| id_src_need | input | 3*NSRC | Per-source stage code at which the operand is needed |
| haz_hit | output | NSRC | Per-source hazard found (first offered cycle only) |
| haz_stage | output | 3*NSRC | Per-source stage code of the youngest producer |

## Verification
A wrong record in the scoreboard shows at the ports only when a later source names the same tag. The fault then appears within the four cycles that the record takes to reach writeback, either as a wrong `haz_stage` in the first offered cycle or as a stall that is too long or too short. A stuck countdown shows up directly as `id_ready` staying low, or rising, one cycle off. Bubble faults (a held instruction that gets recorded) appear only when the offending copy outlives the real producer, so the bench reads its tag again from deeper stages.

// File: rtl/ssi_pkg.sv
`timescale 1ns/1ps
package ssi_pkg;
  localparam int STG_W = 3;
  localparam int TAG_W = 6;

  typedef logic [STG_W-1:0] stage_t;
  typedef logic [TAG_W-1:0] tag_t;

  localparam tag_t TAG_ZERO = 6'd0;
  localparam tag_t TAG_HILO = 6'd32;

  // One scoreboard record; its slot index encodes the distance from decode.
  typedef struct packed {
    logic   vld;
    tag_t   tag;
    stage_t rdy;
  } sb_entry_t;
endpackage

// File: rtl/ssi_scoreboard.sv
`timescale 1ns/1ps
module ssi_scoreboard import ssi_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  sb_entry_t             push_i,
  output sb_entry_t [DEPTH-1:0] ents_o
);
  // Slot 0 is the first execute stage; every cycle each record moves one slot on.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ents_o[i] <= '0;
      end else if (i == 0) begin
        ents_o[i] <= push_i;
      end else begin
        ents_o[i] <= ents_o[i-1];
      end
    end
  end

  // R3: no record ever carries the zero tag
  a_r3_no_zero_record: assert property (@(posedge clk) disable iff (!rst_n)
    ents_o[0].vld |-> (ents_o[0].tag != TAG_ZERO));
endmodule

// File: rtl/ssi_lookup.sv
`timescale 1ns/1ps
module ssi_lookup import ssi_pkg::*; #(
  parameter int DEPTH    = 4,
  parameter int ID_STAGE = 2,
  parameter int CNT_W    = 3,
  parameter int MAX_WAIT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_i,
  input  tag_t                  tag_i,
  input  stage_t                need_i,
  input  sb_entry_t [DEPTH-1:0] ents_i,
  output logic                  hit_o,
  output stage_t                stage_o,
  output logic [CNT_W-1:0]      wait_o
);
  stage_t sel_rdy;
  int     sel_d;
  int     slack;

  // Scan from oldest to youngest so the youngest match overrides.
  always_comb begin
    hit_o   = 1'b0;
    sel_rdy = '0;
    sel_d   = 0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (en_i && (tag_i != TAG_ZERO) && ents_i[i].vld && (ents_i[i].tag == tag_i)) begin
        hit_o   = 1'b1;
        sel_rdy = ents_i[i].rdy;
        sel_d   = i + 1;
      end
    end
    slack   = int'(sel_rdy) - int'(need_i) - sel_d;
    wait_o  = (hit_o && slack > 0) ? CNT_W'(slack) : '0;
    stage_o = hit_o ? STG_W'(ID_STAGE + sel_d) : '0;
  end

  // R3: a zero source tag never reports a hazard
  a_r3_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_i == TAG_ZERO) |-> !hit_o);
  // R2: the per-source wait never exceeds the deepest possible gap
  a_r2_wait_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wait_o) <= MAX_WAIT);
  // R6: a reported stage always lies between the first execute and the last memory stage
  a_r6_stage_range: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (int'(stage_o) > ID_STAGE && int'(stage_o) <= ID_STAGE + DEPTH));
endmodule

// File: rtl/ssi_stall_ctrl.sv
`timescale 1ns/1ps
module ssi_stall_ctrl #(
  parameter int NSRC     = 2,
  parameter int CNT_W    = 3,
  parameter int MAX_WAIT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  id_valid,
  input  logic [NSRC*CNT_W-1:0] wait_i,
  output logic                  id_ready,
  output logic                  first_o
);
  logic [CNT_W-1:0] mx;
  logic [CNT_W-1:0] cnt_q;
  logic             hold_q;

  always_comb begin
    mx = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (wait_i[s*CNT_W +: CNT_W] > mx) mx = wait_i[s*CNT_W +: CNT_W];
    end
  end

  assign first_o  = id_valid && !hold_q;
  assign id_ready = first_o ? (mx == '0) : (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hold_q <= id_valid && !id_ready;
      if (first_o) begin
        cnt_q <= (mx == '0) ? '0 : mx - 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R5: a held instruction stays offered
  a_r5_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> id_valid);
  // R5: the remaining count drains by one per held cycle
  a_r5_count_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R2: the countdown stays below the largest wait
  a_r2_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < MAX_WAIT);
endmodule

// File: rtl/ssi_interlock.sv
`timescale 1ns/1ps
module ssi_interlock import ssi_pkg::*; #(
  parameter int NSRC     = 2,
  parameter int ID_STAGE = 2,
  parameter int WB_STAGE = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  id_valid,
  output logic                  id_ready,
  input  logic                  id_dst_en,
  input  logic [5:0]            id_dst_tag,
  input  logic [2:0]            id_dst_rdy,
  input  logic [NSRC-1:0]       id_src_en,
  input  logic [NSRC*6-1:0]     id_src_tag,
  input  logic [NSRC*3-1:0]     id_src_need,
  output logic [NSRC-1:0]       haz_hit,
  output logic [NSRC*3-1:0]     haz_stage
);
  localparam int SB_DEPTH = WB_STAGE - ID_STAGE - 1;
  localparam int MAX_WAIT = WB_STAGE - ID_STAGE - 1;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  sb_entry_t [SB_DEPTH-1:0] sb_ents;
  sb_entry_t                push;
  logic [NSRC*CNT_W-1:0]    waits;
  logic [NSRC-1:0]          hits;
  logic [NSRC*3-1:0]        stages;
  logic                     first;

  // Accepted destination enters the first slot; otherwise a bubble does.
  always_comb begin
    push.vld = id_valid && id_ready && id_dst_en && (id_dst_tag != TAG_ZERO);
    push.tag = id_dst_tag;
    push.rdy = id_dst_rdy;
  end

  ssi_scoreboard #(.DEPTH(SB_DEPTH)) u_sb (
    .clk(clk), .rst_n(rst_n), .push_i(push), .ents_o(sb_ents)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    ssi_lookup #(
      .DEPTH(SB_DEPTH), .ID_STAGE(ID_STAGE), .CNT_W(CNT_W), .MAX_WAIT(MAX_WAIT)
    ) u_lk (
      .clk(clk), .rst_n(rst_n),
      .en_i(id_src_en[s]),
      .tag_i(id_src_tag[s*6 +: 6]),
      .need_i(id_src_need[s*3 +: 3]),
      .ents_i(sb_ents),
      .hit_o(hits[s]),
      .stage_o(stages[s*3 +: 3]),
      .wait_o(waits[s*CNT_W +: CNT_W])
    );
  end

  ssi_stall_ctrl #(.NSRC(NSRC), .CNT_W(CNT_W), .MAX_WAIT(MAX_WAIT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .wait_i(waits),
    .id_ready(id_ready), .first_o(first)
  );

  assign haz_hit   = first ? hits : '0;
  assign haz_stage = first ? stages : '0;

  // R7: a held cycle injects a bubble into the first slot
  a_r7_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !id_ready) |=> !sb_ents[0].vld);
  // R5: offered fields stay put while held
  a_r5_stable_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !id_ready) |=> (id_valid && $stable(id_src_tag) && $stable(id_dst_tag)));
  // R6: no hazard report during the held cycles
  a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !id_ready) |=> (haz_hit == '0));
endmodule

// File: tb/tb_ssi_interlock.sv
`timescale 1ns/1ps
module tb_ssi_interlock;
  localparam int NSRC = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              id_valid;
  logic              id_ready;
  logic              id_dst_en;
  logic [5:0]        id_dst_tag;
  logic [2:0]        id_dst_rdy;
  logic [NSRC-1:0]   id_src_en;
  logic [NSRC*6-1:0] id_src_tag;
  logic [NSRC*3-1:0] id_src_need;
  logic [NSRC-1:0]   haz_hit;
  logic [NSRC*3-1:0] haz_stage;

  ssi_interlock dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // Bench-side pipeline record: index 1..4 is distance ahead of decode.
  logic       m_v [1:4];
  logic [5:0] m_t [1:4];
  logic [2:0] m_r [1:4];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic shift(input bit v, input logic [5:0] t, input logic [2:0] r);
    for (int i = 4; i > 1; i--) begin
      m_v[i] = m_v[i-1]; m_t[i] = m_t[i-1]; m_r[i] = m_r[i-1];
    end
    m_v[1] = v; m_t[1] = t; m_r[1] = r;
  endtask

  task automatic expect_src(input bit en, input logic [5:0] t, input logic [2:0] need,
                            output bit hit, output int stg, output int w);
    hit = 0; stg = 0; w = 0;
    if (en && t != 0) begin
      for (int d = 1; d <= 4; d++) begin
        if (!hit && m_v[d] && m_t[d] == t) begin
          hit = 1;
          stg = 2 + d;
          w   = int'(m_r[d]) - int'(need) - d;
          if (w < 0) w = 0;
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); id_valid = 1'b0;
      @(posedge clk); shift(0, 0, 0);
    end
  endtask

  task automatic issue(input bit de, input logic [5:0] dt, input logic [2:0] dr,
                       input bit e0, input logic [5:0] t0, input logic [2:0] n0,
                       input bit e1, input logic [5:0] t1, input logic [2:0] n1,
                       input string req);
    bit h0, h1, rdy;
    int s0, s1, w0, w1, ew, stalls;
    @(negedge clk);
    id_valid = 1'b1; id_dst_en = de; id_dst_tag = dt; id_dst_rdy = dr;
    id_src_en = {e1, e0}; id_src_tag = {t1, t0}; id_src_need = {n1, n0};
    #1;
    expect_src(e0, t0, n0, h0, s0, w0);
    expect_src(e1, t1, n1, h1, s1, w1);
    ew = (w0 > w1) ? w0 : w1;
    chk(haz_hit[0] == h0, req, "src0 hit", int'(haz_hit[0]), int'(h0));
    chk(int'(haz_stage[2:0]) == s0, req, "src0 stage", int'(haz_stage[2:0]), s0);
    chk(haz_hit[1] == h1, req, "src1 hit", int'(haz_hit[1]), int'(h1));
    chk(int'(haz_stage[5:3]) == s1, req, "src1 stage", int'(haz_stage[5:3]), s1);
    stalls = 0;
    forever begin
      rdy = id_ready;
      @(posedge clk);
      if (rdy) shift(de && dt != 0, dt, dr);
      else     shift(0, 0, 0);
      if (rdy || stalls > 8) break;
      stalls++;
      @(negedge clk); #1;
      // R6: held cycles report nothing
      chk(haz_hit == '0, "R6", "hit while held", int'(haz_hit), 0);
    end
    // R5: ready is low for exactly the stall count
    chk(stalls == ew, req, "stall cycles", stalls, ew);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [5:0] tagset [0:4];
    logic [2:0] rdyset [0:2];
    logic [2:0] needset[0:2];
    tagset = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd32};
    rdyset = '{3'd3, 3'd5, 3'd7};
    needset = '{3'd2, 3'd3, 3'd5};
    for (int i = 1; i <= 4; i++) begin m_v[i] = 0; m_t[i] = 0; m_r[i] = 0; end
    rst_n = 1'b0; id_valid = 1'b0; id_dst_en = 1'b0; id_dst_tag = '0; id_dst_rdy = '0;
    id_src_en = '0; id_src_tag = '0; id_src_need = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1: reset state
    chk(id_ready == 1'b1, "R1", "ready after reset", int'(id_ready), 1);
    chk(haz_hit == '0, "R1", "hit after reset", int'(haz_hit), 0);
    issue(0, 0, 0, 1, 6'd5, 3'd2, 1, 6'd32, 3'd3, "R1");

    // R2 / R9: sweep producer kind, distance and need stage
    for (int k = 0; k < 3; k++)
      for (int g = 0; g <= 4; g++)
        for (int n = 0; n < 3; n++) begin
          idle(5);
          issue(1, 6'd9, rdyset[k], 0, 0, 0, 0, 0, 0, "R2");
          idle(g);
          issue(0, 0, 0, 1, 6'd9, needset[n], 0, 0, 0, (g == 4) ? "R9" : "R2");
        end

    // R3: zero tag as destination and as source
    idle(5);
    issue(1, 6'd0, 3'd7, 0, 0, 0, 0, 0, 0, "R3");
    issue(0, 0, 0, 1, 6'd0, 3'd2, 1, 6'd0, 3'd3, "R3");
    chk(haz_hit == '0, "R3", "zero tag hit", int'(haz_hit), 0);

    // R4: youngest producer decides (2 stalls, not 3)
    idle(5);
    issue(1, 6'd4, 3'd7, 0, 0, 0, 0, 0, 0, "R4");
    issue(1, 6'd4, 3'd5, 0, 0, 0, 0, 0, 0, "R4");
    issue(0, 0, 0, 1, 6'd4, 3'd2, 0, 0, 0, "R4");
    // and the reverse order (4 stalls)
    idle(5);
    issue(1, 6'd4, 3'd5, 0, 0, 0, 0, 0, 0, "R4");
    issue(1, 6'd4, 3'd7, 0, 0, 0, 0, 0, 0, "R4");
    issue(0, 0, 0, 1, 6'd4, 3'd2, 0, 0, 0, "R4");

    // R8: hi/lo pair written by a multiply, read by a move
    idle(5);
    issue(1, 6'd32, 3'd7, 0, 0, 0, 0, 0, 0, "R8");
    issue(0, 0, 0, 0, 0, 0, 1, 6'd32, 3'd3, "R8");

    // R10: two sources, larger wait wins (3 stalls, stages 4 and 3)
    idle(5);
    issue(1, 6'd1, 3'd5, 0, 0, 0, 0, 0, 0, "R10");
    issue(1, 6'd2, 3'd7, 0, 0, 0, 0, 0, 0, "R10");
    issue(0, 0, 0, 1, 6'd1, 3'd3, 1, 6'd2, 3'd3, "R10");

    // R7: the held instruction's destination is recorded once, not per bubble
    idle(5);
    issue(1, 6'd5, 3'd7, 0, 0, 0, 0, 0, 0, "R7");
    issue(1, 6'd6, 3'd5, 1, 6'd5, 3'd3, 0, 0, 0, "R7");
    idle(3);
    issue(0, 0, 0, 1, 6'd6, 3'd2, 0, 0, 0, "R7");

    // R2 / R4 / R5: random streams over a small tag set
    idle(5);
    for (int it = 0; it < 600; it++) begin
      issue($urandom_range(0, 1), tagset[$urandom_range(0, 4)], rdyset[$urandom_range(0, 2)],
            $urandom_range(0, 1), tagset[$urandom_range(0, 4)], needset[$urandom_range(0, 2)],
            $urandom_range(0, 1), tagset[$urandom_range(0, 4)], needset[$urandom_range(0, 2)],
            "R5");
      if ($urandom_range(0, 3) == 0) idle(1);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule